// File: doc/BRIEF.md
# CPU PLL Divider Change Sequencer

This block changes the integer feedback divider of the CPU clock PLL in a safe order. A request carries a target frequency in Hz. The block first limits the target to the ceiling set by a 2-bit fuse speed grade. It then works out the divider and forces it into a legal window.

To change the divider, the block parks the CPU on the reference clock by selecting bypass source 0 and setting bypass. It then writes the new divider and waits for the PLL to report lock. Bypass is released only after lock arrives. If lock never arrives within a bounded number of polls, the block stops in a sticky error state and leaves the CPU on the reference clock.

After reset the block runs one sequence without any request, bringing the CPU up to the ceiling for its speed grade. Software or a thermal controller then issues requests. It waits for `busy_o` to drop, and reads the new frequency on the cycle `done_o` pulses. The minimum operating point is also exported so that a throttling agent can request it.

Top module: `pll_freq_seq`

## Requirements
- R1: After reset is released, with no request, the block runs one sequence to the ceiling frequency of the current speed code. During reset `busy_o`=1, `div_o`=0, `bypass_o`=0, `lock_err_o`=0, `cur_hz_o`=0.
- R2: The ceiling is the speed-grade base value rounded through the divider formula. The base values are code 0 → 792 MHz, 1 → 852 MHz, 2 → 996 MHz and 3 → 1200 MHz, giving ceilings of 792, 840, 984 and 1200 MHz. `min_hz_o` is always 792000000.
- R3: The divider written is min(request, ceiling) / 12000000, using integer division. The result is then clamped to the inclusive range 54..108.
- R4: The divider output changes only while `bypass_o`=1 and `bypass_src_o`=0. Both of these are set before the divider changes.
- R5: Bypass is released only after the PLL lock input was seen high, and no sooner than 2 cycles after the divider changed.
- R6: If lock is not seen within 10000 polls, `lock_err_o` rises and stays high until reset. In that state `bypass_o` stays 1 and `busy_o` stays 1.
- R7: `cur_hz_o` = 24000000 × (divider / 2), using integer halving of the divider. `cur_mhz_o` = `cur_hz_o` / 1000000. Both change only on the cycle `done_o` is high.
- R8: `done_o` is a single-cycle pulse that marks the end of each sequence. After that pulse, `busy_o` is 0.
- R9: A request asserted while `busy_o`=1 is ignored. The divider then reflects only the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken only when not busy |
| req_hz_i | input | 32 | Requested CPU frequency in Hz |
| speed_code_i | input | 2 | Fuse speed grade code |
| pll_lock_i | input | 1 | PLL lock indication |
| div_o | output | 7 | PLL feedback divider |
| bypass_o | output | 1 | Run the CPU from the bypass clock |
| bypass_src_o | output | 2 | Bypass clock source select (0 = reference) |
| busy_o | output | 1 | Sequence in progress, or stopped in error |
| done_o | output | 1 | One-cycle sequence-complete pulse |
| lock_err_o | output | 1 | Sticky lock-timeout error |
| cur_hz_o | output | 32 | Current CPU frequency in Hz |
| cur_mhz_o | output | 11 | Current CPU frequency in whole MHz |
| max_hz_o | output | 32 | Ceiling frequency for the speed code |
| min_hz_o | output | 32 | Minimum operating frequency |

## Verification
Several ordering rules are checked by the assertions on every cycle:
- the divider moves only under reference bypass and inside its legal window;
- bypass falls only after lock was seen high;
- the error flag is sticky and keeps bypass set;
- the reported frequency moves only on the done pulse.

Other behaviour can only be shown by the bench's scenarios: the arithmetic of clipping, dividing, clamping and rounding, the per-grade ceilings, the start-up run, and the dropping of requests made while busy. The bench checks these against computed values over random requests and the boundary targets. A PLL model that never locks drives the timeout path.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_SRC, ST_BYP, ST_DIV, ST_WAIT, ST_REL, ST_ERR
  } seq_state_e;

  localparam int unsigned GRADES = 4;
  localparam logic [63:0] GRADE_HZ [GRADES] = '{
    64'd792000000, 64'd852000000, 64'd996000000, 64'd1200000000
  };

  // output frequency for a divider: ref * floor(div/2)
  function automatic logic [63:0] div_to_hz(input logic [63:0] d, input logic [63:0] ref_hz);
    return ref_hz * (d >> 1);
  endfunction

  function automatic logic [63:0] round_hz(input logic [63:0] hz, input logic [63:0] ref_hz);
    return div_to_hz(hz / (ref_hz >> 1), ref_hz);
  endfunction
endpackage

// File: rtl/pll_max_sel.sv
module pll_max_sel #(
  parameter int unsigned HZ_W   = 32,
  parameter int unsigned CODE_W = 2,
  parameter longint unsigned REF_HZ = 24000000
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [HZ_W-1:0]   max_hz_o,
  output logic [HZ_W-1:0]   min_hz_o
);
  import pll_seq_pkg::*;
  localparam int unsigned N = 1 << CODE_W;

  logic [HZ_W-1:0] grade_hz [N];

  for (genvar g = 0; g < N; g++) begin : g_grade
    localparam logic [63:0] RND = round_hz(GRADE_HZ[g % GRADES], 64'(REF_HZ));
    assign grade_hz[g] = RND[HZ_W-1:0];
  end

  assign max_hz_o = grade_hz[code_i];
  assign min_hz_o = grade_hz[0];
endmodule

// File: rtl/pll_div_calc.sv
module pll_div_calc #(
  parameter int unsigned HZ_W    = 32,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned DIV_MIN = 54,
  parameter int unsigned DIV_MAX = 108,
  parameter longint unsigned REF_HZ = 24000000
) (
  input  logic [HZ_W-1:0]  req_hz_i,
  input  logic [HZ_W-1:0]  max_hz_i,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [63:0] HALF_REF = 64'(REF_HZ / 2);

  logic [HZ_W-1:0] clip_hz;
  logic [63:0]     quot;

  always_comb begin
    clip_hz = (req_hz_i < max_hz_i) ? req_hz_i : max_hz_i;
    quot    = 64'(clip_hz) / HALF_REF;
    if (quot < 64'(DIV_MIN))      div_o = DIV_W'(DIV_MIN);
    else if (quot > 64'(DIV_MAX)) div_o = DIV_W'(DIV_MAX);
    else                          div_o = quot[DIV_W-1:0];
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm #(
  parameter int unsigned DIV_W      = 7,
  parameter int unsigned LOCK_POLLS = 10000,
  parameter int unsigned SETTLE     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [DIV_W-1:0] req_div_i,
  input  logic [DIV_W-1:0] boot_div_i,
  input  logic             pll_lock_i,
  output logic [DIV_W-1:0] div_o,
  output logic             bypass_o,
  output logic [1:0]       bypass_src_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             lock_err_o,
  output logic [DIV_W-1:0] tgt_div_o
);
  import pll_seq_pkg::*;
  localparam int unsigned CNT_W = $clog2(LOCK_POLLS + SETTLE + 1);

  seq_state_e       state_q;
  logic [DIV_W-1:0] tgt_q, div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             byp_q, done_q;
  logic [1:0]       src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      tgt_q   <= '0;
      div_q   <= '0;
      cnt_q   <= '0;
      byp_q   <= 1'b0;
      src_q   <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_BOOT: begin
          tgt_q   <= boot_div_i;
          state_q <= ST_SRC;
        end
        ST_IDLE: if (req_valid_i) begin
          tgt_q   <= req_div_i;
          state_q <= ST_SRC;
        end
        ST_SRC: begin
          src_q   <= 2'd0;  // reference clock feeds bypass
          state_q <= ST_BYP;
        end
        ST_BYP: begin
          byp_q   <= 1'b1;
          state_q <= ST_DIV;
        end
        ST_DIV: begin
          div_q   <= tgt_q;
          cnt_q   <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          // lock is ignored for SETTLE cycles so a stale lock is not taken
          if (cnt_q >= CNT_W'(SETTLE) && pll_lock_i) state_q <= ST_REL;
          else if (cnt_q == CNT_W'(LOCK_POLLS + SETTLE)) state_q <= ST_ERR;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_REL: begin
          byp_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_ERR: state_q <= ST_ERR;
        default: state_q <= ST_ERR;
      endcase
    end
  end

  assign div_o        = div_q;
  assign bypass_o     = byp_q;
  assign bypass_src_o = src_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign lock_err_o   = (state_q == ST_ERR);
  assign tgt_div_o    = tgt_q;
endmodule

// File: rtl/pll_freq_seq.sv
module pll_freq_seq #(
  parameter int unsigned HZ_W       = 32,
  parameter int unsigned MHZ_W      = 11,
  parameter int unsigned DIV_W      = 7,
  parameter int unsigned CODE_W     = 2,
  parameter int unsigned DIV_MIN    = 54,
  parameter int unsigned DIV_MAX    = 108,
  parameter int unsigned LOCK_POLLS = 10000,
  parameter int unsigned SETTLE     = 2,
  parameter longint unsigned REF_HZ = 24000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [HZ_W-1:0]   req_hz_i,
  input  logic [CODE_W-1:0] speed_code_i,
  input  logic              pll_lock_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              bypass_o,
  output logic [1:0]        bypass_src_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              lock_err_o,
  output logic [HZ_W-1:0]   cur_hz_o,
  output logic [MHZ_W-1:0]  cur_mhz_o,
  output logic [HZ_W-1:0]   max_hz_o,
  output logic [HZ_W-1:0]   min_hz_o
);
  import pll_seq_pkg::*;

  logic [DIV_W-1:0] req_div, boot_div, tgt_div;
  logic             done;
  logic [63:0]      new_hz;

  pll_max_sel #(.HZ_W(HZ_W), .CODE_W(CODE_W), .REF_HZ(REF_HZ)) u_max (
    .code_i(speed_code_i), .max_hz_o(max_hz_o), .min_hz_o(min_hz_o)
  );

  pll_div_calc #(.HZ_W(HZ_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
                 .REF_HZ(REF_HZ)) u_req_div (
    .req_hz_i(req_hz_i), .max_hz_i(max_hz_o), .div_o(req_div)
  );

  pll_div_calc #(.HZ_W(HZ_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
                 .REF_HZ(REF_HZ)) u_boot_div (
    .req_hz_i(max_hz_o), .max_hz_i(max_hz_o), .div_o(boot_div)
  );

  pll_seq_fsm #(.DIV_W(DIV_W), .LOCK_POLLS(LOCK_POLLS), .SETTLE(SETTLE)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_div_i(req_div), .boot_div_i(boot_div), .pll_lock_i(pll_lock_i),
    .div_o(div_o), .bypass_o(bypass_o), .bypass_src_o(bypass_src_o),
    .busy_o(busy_o), .done_o(done), .lock_err_o(lock_err_o), .tgt_div_o(tgt_div)
  );

  assign new_hz = div_to_hz(64'(tgt_div), 64'(REF_HZ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_hz_o  <= '0;
      cur_mhz_o <= '0;
    end else if (u_fsm.state_q == ST_REL) begin
      cur_hz_o  <= new_hz[HZ_W-1:0];
      cur_mhz_o <= MHZ_W'(new_hz / 64'd1000000);
    end
  end

  assign done_o = done;
endmodule

// File: rtl/pll_freq_seq_chk.sv
module pll_freq_seq_chk #(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned HZ_W    = 32,
  parameter int unsigned DIV_MIN = 54,
  parameter int unsigned DIV_MAX = 108
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pll_lock_i,
  input logic [DIV_W-1:0] div_o,
  input logic             bypass_o,
  input logic [1:0]       bypass_src_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             lock_err_o,
  input logic [HZ_W-1:0]  cur_hz_o
);
  p_div_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> (div_o >= DIV_W'(DIV_MIN) && div_o <= DIV_W'(DIV_MAX)));

  p_div_under_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> ($past(bypass_o) && bypass_o && bypass_src_o == 2'd0));

  p_release_after_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bypass_o) |-> $past(pll_lock_i, 2));

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_o |=> (lock_err_o && bypass_o && busy_o));

  p_cur_on_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_hz_o) |-> done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind pll_freq_seq pll_freq_seq_chk #(
  .DIV_W(DIV_W), .HZ_W(HZ_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pll_lock_i(pll_lock_i), .div_o(div_o),
  .bypass_o(bypass_o), .bypass_src_o(bypass_src_o), .busy_o(busy_o),
  .done_o(done_o), .lock_err_o(lock_err_o), .cur_hz_o(cur_hz_o)
);

// File: tb/pll_freq_seq_tb.sv
module pll_freq_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_hz = '0;
  logic [1:0]  code = 2'd2;
  logic        lock = 1'b1;
  logic [6:0]  div;
  logic        byp, busy, done, lerr;
  logic [1:0]  src;
  logic [31:0] cur_hz, max_hz, min_hz;
  logic [10:0] cur_mhz;

  int checks = 0, errors = 0, cyc = 0;
  bit never_lock = 1'b0;
  int lat = 4;

  always #2 clk = ~clk;

  pll_freq_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_hz_i(req_hz),
    .speed_code_i(code), .pll_lock_i(lock), .div_o(div), .bypass_o(byp),
    .bypass_src_o(src), .busy_o(busy), .done_o(done), .lock_err_o(lerr),
    .cur_hz_o(cur_hz), .cur_mhz_o(cur_mhz), .max_hz_o(max_hz), .min_hz_o(min_hz)
  );

  // PLL model: lock drops on a divider change, returns lat cycles later
  logic [6:0] div_seen = '0;
  int lcnt = 0;
  always @(posedge clk) begin
    if (div != div_seen) begin
      div_seen <= div; lock <= 1'b0; lcnt <= 0;
    end else if (never_lock) lock <= 1'b0;
    else if (lcnt < lat) lcnt <= lcnt + 1;
    else lock <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ordering monitor
  logic [6:0] div_p = '0;
  logic byp_p = 1'b0, lock_p = 1'b0;
  int order_bad = 0, rel_bad = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (div != div_p && !(byp && src == 2'd0)) order_bad++;      // R4
      if (byp_p && !byp && !lock_p) rel_bad++;                     // R5
    end
    div_p = div; byp_p = byp; lock_p = lock;
  end

  function automatic longint ceil_hz(input logic [1:0] c);
    longint base [4] = '{792000000, 852000000, 996000000, 1200000000};
    return 64'd24000000 * ((base[c] / 12000000) / 2);
  endfunction

  function automatic longint exp_div(input longint r, input logic [1:0] c);
    longint m = ceil_hz(c);
    longint d = ((r < m) ? r : m) / 12000000;
    if (d < 54) d = 54;
    if (d > 108) d = 108;
    return d;
  endfunction

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic request(input longint hz, input string tag);
    bit got;
    longint d, h;
    while (busy) @(negedge clk);
    d = exp_div(hz, code);
    h = 24000000 * (d / 2);
    req_hz = 32'(hz); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(got);
    chk(got, {tag, " R8 done seen"}, got, 1);
    chk(div == 7'(d), {tag, " R3 divider"}, div, d);
    chk(cur_hz == 32'(h), {tag, " R7 cur_hz"}, cur_hz, h);
    chk(cur_mhz == 11'(h / 1000000), {tag, " R7 cur_mhz"}, cur_mhz, h / 1000000);
    @(negedge clk);
    chk(!done && !busy && !byp, {tag, " R8 pulse end"}, {done, busy, byp}, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    bit got;
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1 reset state
    chk(busy && div == 0 && !byp && !lerr && cur_hz == 0, "R1 reset state",
        {busy, div, byp, lerr}, 64'h100);
    do_reset();
    wait_done(got);
    chk(got && div == 7'(exp_div(ceil_hz(2), 2)), "R1 boot divider", div, exp_div(ceil_hz(2), 2));
    chk(cur_mhz == 11'd984, "R1 boot MHz", cur_mhz, 984);

    // R2 ceilings per grade
    for (int c = 0; c < 4; c++) begin
      code = 2'(c);
      @(negedge clk);
      chk(max_hz == 32'(ceil_hz(2'(c))), "R2 ceiling", max_hz, ceil_hz(2'(c)));
      chk(min_hz == 32'd792000000, "R2 minimum", min_hz, 792000000);
    end
    code = 2'd3;
    request(64'd2000000000, "over-ceiling");
    request(64'd100000000, "low clamp");
    request(64'd647999999, "below 54");
    request(64'd648000000, "at 54");
    request(64'd852000000, "odd divider");
    code = 2'd1;
    request(64'd1000000000, "grade1 clip");

    // R9 request while busy is ignored
    code = 2'd3;
    req_hz = 32'd900000000; req_valid = 1'b1;
    @(negedge clk);
    req_hz = 32'd700000000;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done(got);
    chk(div == 7'(exp_div(900000000, 3)), "R9 busy request ignored", div, exp_div(900000000, 3));
    @(negedge clk);

    // random mix
    for (int i = 0; i < 40; i++) begin
      code = 2'($urandom_range(0, 3));
      lat = $urandom_range(0, 9);
      request(longint'($urandom_range(0, 1400000000)), "random");
    end

    chk(order_bad == 0, "R4 divider only under ref bypass", order_bad, 0);
    chk(rel_bad == 0, "R5 release after lock", rel_bad, 0);

    // R6 lock timeout
    never_lock = 1'b1;
    req_hz = 32'd700000000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10100) @(negedge clk);
    chk(lerr, "R6 lock error raised", lerr, 1);
    chk(byp && busy && !done, "R6 bypass held", {byp, busy, done}, 6);
    req_valid = 1'b1; req_hz = 32'd1200000000;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    chk(lerr && byp, "R6 error sticky", {lerr, byp}, 3);

    never_lock = 1'b0; code = 2'd0;
    do_reset();
    chk(!lerr, "R1 error cleared by reset", lerr, 0);
    wait_done(got);
    chk(cur_hz == 32'd792000000, "R1 reboot grade0", cur_hz, 792000000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule